// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one DDR2 channel from power-on to a usable state. After reset it raises the clock enable, holds the bus in NOP for a long stabilisation interval, and then walks through the fixed JEDEC-style series of commands. The series is: precharge-all, extended mode register (EMRS) write enabling the DLL, mode register (MRS) write resetting the DLL, a second precharge-all, eight auto-refreshes, the final MRS, and two EMRS writes for off-chip driver (OCD) calibration. It drives the command pins, bank address and row address directly from registers. All wait intervals are parameters counted in controller clocks.

The final mode word is assembled from configuration inputs: CAS latency code, a burst length select (4 or 8) and a write recovery code. The on-die termination written into the extended mode register follows the number of DIMMs on the channel: 150 Ω for one DIMM, 75 Ω for two. Any other count is unsupported. In that case the termination-dependent EMRS writes are left out and an error flag is raised, while the rest of the series still runs. A `start` pulse throws away all progress and replays the series from the beginning. `init_done` reports completion and stays high until reset or a restart.

Top module: `ddr2_pwrup_seq`

## Requirements
- R1: While reset is held, `cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} are 1111, and `init_done` and `error` are 0. In the first cycle after reset is released, `cke` is 1 and the pins carry NOP (0111).
- R2: Command pin codes {cs_n,ras_n,cas_n,we_n} are: NOP 0111, precharge 0010, auto-refresh 0001, and MRS/EMRS 0000. With a supported DIMM count, exactly 15 non-NOP commands are issued in the order given above. Any cycle without a command carries NOP once `cke` is high.
- R3: Each precharge-all drives `addr` = 0x400 (only A10 set) and `ba` = 0.
- R4: The DLL-enable EMRS drives `ba` = 1 and `addr` = the termination bits alone. These are A6 (0x040) for one DIMM and A2 (0x004) for two DIMMs. The DLL-reset MRS drives `ba` = 0 and `addr` = 0x100 (A8).
- R5: Eight auto-refreshes are issued with `ba` = 0 and `addr` = 0. Consecutive refreshes are exactly T_REF_GAP cycles apart. The final MRS follows the last refresh by exactly T_RFC cycles.
- R6: The final MRS drives `ba` = 0 and `addr` = {wr_rec in A11:A9, 0 in A8:A7, cas_lat in A6:A4, 1 in A3, A2:A0 = 011 when `bl8_sel` is 1 else 010}.
- R7: The OCD-default EMRS drives `ba` = 1 and `addr` = 0x380 OR the termination bits. The OCD-exit EMRS that follows drives `ba` = 1 and `addr` = the termination bits alone.
- R8: The first precharge comes exactly T_STABLE cycles after `cke` rises. Any command after a precharge comes exactly T_RP cycles after it. Any command after an MRS/EMRS comes exactly T_MRD cycles after it.
- R9: With `dimm_cnt` not 1 or 2, the three EMRS writes are skipped. The DLL-reset MRS then follows the first precharge by T_RP, and the sequence ends after the final MRS. `error` rises together with `cke` and stays high until reset or restart.
- R10: `init_done` rises exactly T_MRD cycles after the last command of the series. It then stays high with only NOP on the pins until reset or restart.
- R11: A cycle with `start` high causes the reset state of R1 (`cke` 0, pins 1111, `init_done` 0, `error` 0) in the next cycle. The complete series then replays from the NOP step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the power-up series from the beginning |
| dimm_cnt | input | 2 | Number of DIMMs on the channel (1 or 2 supported) |
| cas_lat | input | 3 | CAS latency code placed in A6:A4 of the final MRS |
| bl8_sel | input | 1 | 1 selects burst length 8, 0 selects 4 |
| wr_rec | input | 3 | Write recovery code placed in A11:A9 of the final MRS |
| cke | output | 1 | Clock enable to the DRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Row address / mode word |
| init_done | output | 1 | Series complete |
| error | output | 1 | Unsupported DIMM count seen |

## Verification
The embedded assertions check several properties on every cycle:
- every precharge carries A10 and bank 0;
- no command follows a mode register write sooner than T_MRD;
- no EMRS appears while the error flag is up;
- commands appear only with `cke` high;
- `init_done` holds with a quiet bus;
- a restart clears the outputs on the next cycle.

The exact order of the series, the mode words built from CAS latency, burst length, write recovery and DIMM count, and the precise T_STABLE, T_RP, T_REF_GAP and T_RFC spacings can only be shown by the bench's scenarios. These scenarios log every command with its cycle and compare it against a series built independently for each configuration, including unsupported counts and restarts in mid-series and after completion.

// File: rtl/ddr2_pwrup_pkg.sv
package ddr2_pwrup_pkg;

    // Steps of the power-up series, in issue order
    typedef enum logic [3:0] {
        STP_PWR_NOP    = 4'd0,
        STP_PRE_A      = 4'd1,
        STP_EMRS_DLL   = 4'd2,
        STP_MRS_DLLRST = 4'd3,
        STP_PRE_B      = 4'd4,
        STP_AREF       = 4'd5,
        STP_MRS_FINAL  = 4'd6,
        STP_OCD_DEF    = 4'd7,
        STP_OCD_EXIT   = 4'd8,
        STP_DONE       = 4'd9
    } step_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } cmd_e;

endpackage

// File: rtl/ddr2_step_plan.sv
// Per-step command, interval and successor selection.
module ddr2_step_plan
    import ddr2_pwrup_pkg::*;
#(
    parameter int T_STABLE  = 80000,
    parameter int T_RP      = 6,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 52,
    parameter int T_REF_GAP = 40000,
    parameter int CNT_W     = 17
) (
    input  step_e              step,
    input  logic               count_ok,
    input  logic               last_ref,
    output cmd_e               cmd,
    output logic [CNT_W-1:0]   gap_m1,
    output step_e              next_step
);

    localparam logic [CNT_W-1:0] G_STABLE = CNT_W'(T_STABLE - 1);
    localparam logic [CNT_W-1:0] G_RP     = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] G_MRD    = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] G_RFC    = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] G_REF    = CNT_W'(T_REF_GAP - 1);

    always_comb begin
        cmd       = CMD_NOP;
        gap_m1    = '0;
        next_step = STP_DONE;
        case (step)
            STP_PWR_NOP: begin
                cmd       = CMD_NOP;
                gap_m1    = G_STABLE;
                next_step = STP_PRE_A;
            end
            STP_PRE_A: begin
                cmd       = CMD_PRE;
                gap_m1    = G_RP;
                next_step = count_ok ? STP_EMRS_DLL : STP_MRS_DLLRST;
            end
            STP_EMRS_DLL: begin
                cmd       = CMD_MRS;
                gap_m1    = G_MRD;
                next_step = STP_MRS_DLLRST;
            end
            STP_MRS_DLLRST: begin
                cmd       = CMD_MRS;
                gap_m1    = G_MRD;
                next_step = STP_PRE_B;
            end
            STP_PRE_B: begin
                cmd       = CMD_PRE;
                gap_m1    = G_RP;
                next_step = STP_AREF;
            end
            STP_AREF: begin
                cmd       = CMD_REF;
                gap_m1    = last_ref ? G_RFC : G_REF;
                next_step = last_ref ? STP_MRS_FINAL : STP_AREF;
            end
            STP_MRS_FINAL: begin
                cmd       = CMD_MRS;
                gap_m1    = G_MRD;
                next_step = count_ok ? STP_OCD_DEF : STP_DONE;
            end
            STP_OCD_DEF: begin
                cmd       = CMD_MRS;
                gap_m1    = G_MRD;
                next_step = STP_OCD_EXIT;
            end
            STP_OCD_EXIT: begin
                cmd       = CMD_MRS;
                gap_m1    = G_MRD;
                next_step = STP_DONE;
            end
            default: begin
                cmd       = CMD_NOP;
                gap_m1    = '0;
                next_step = STP_DONE;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_mode_word.sv
// Bank and address word for each step of the series.
module ddr2_mode_word
    import ddr2_pwrup_pkg::*;
#(
    parameter int ROW_W = 14,
    parameter int BA_W  = 3
) (
    input  step_e             step,
    input  logic [2:0]        cas_lat,
    input  logic              bl8_sel,
    input  logic [2:0]        wr_rec,
    input  logic              odt_75,
    output logic [BA_W-1:0]   ba,
    output logic [ROW_W-1:0]  addr
);

    logic [ROW_W-1:0] term_w;

    always_comb begin
        term_w = '0;
        if (odt_75) term_w[2] = 1'b1;
        else        term_w[6] = 1'b1;
    end

    always_comb begin
        ba   = '0;
        addr = '0;
        case (step)
            STP_PRE_A, STP_PRE_B: begin
                addr[10] = 1'b1;
            end
            STP_EMRS_DLL, STP_OCD_EXIT: begin
                ba[0] = 1'b1;
                addr  = term_w;
            end
            STP_OCD_DEF: begin
                ba[0]     = 1'b1;
                addr      = term_w;
                addr[9:7] = 3'b111;
            end
            STP_MRS_DLLRST: begin
                addr[8] = 1'b1;
            end
            STP_MRS_FINAL: begin
                addr[11:9] = wr_rec;
                addr[6:4]  = cas_lat;
                addr[3]    = 1'b1;
                addr[2:0]  = bl8_sel ? 3'b011 : 3'b010;
            end
            default: begin
                ba   = '0;
                addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/ddr2_pwrup_seq.sv
module ddr2_pwrup_seq
    import ddr2_pwrup_pkg::*;
#(
    parameter int ROW_W     = 14,
    parameter int BA_W      = 3,
    parameter int T_STABLE  = 80000,
    parameter int T_RP      = 6,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 52,
    parameter int T_REF_GAP = 40000,
    parameter int N_REF     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        dimm_cnt,
    input  logic [2:0]        cas_lat,
    input  logic              bl8_sel,
    input  logic [2:0]        wr_rec,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ROW_W-1:0]  addr,
    output logic              init_done,
    output logic              error
);

    localparam int T_MAX_A = (T_STABLE > T_REF_GAP) ? T_STABLE : T_REF_GAP;
    localparam int T_MAX_B = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam int REF_W   = (N_REF > 1) ? $clog2(N_REF) : 1;

    typedef struct packed {
        step_e             step;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  ref_n;
        logic              cke;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ROW_W-1:0]  addr;
        logic              done;
        logic              err;
    } seq_s;

    localparam seq_s SEQ_RST = '{
        step:  STP_PWR_NOP,
        cnt:   '0,
        ref_n: '0,
        cke:   1'b0,
        cmd:   CMD_DESEL,
        ba:    '0,
        addr:  '0,
        done:  1'b0,
        err:   1'b0
    };

    seq_s q, d;

    logic              count_ok;
    logic              odt_75;
    logic              last_ref;
    cmd_e              pl_cmd;
    logic [CNT_W-1:0]  pl_gap_m1;
    step_e             pl_next;
    logic [BA_W-1:0]   wb_ba;
    logic [ROW_W-1:0]  wb_addr;

    assign count_ok = (dimm_cnt == 2'd1) || (dimm_cnt == 2'd2);
    assign odt_75   = (dimm_cnt == 2'd2);
    assign last_ref = (q.ref_n == REF_W'(N_REF - 1));

    ddr2_step_plan #(
        .T_STABLE  (T_STABLE),
        .T_RP      (T_RP),
        .T_MRD     (T_MRD),
        .T_RFC     (T_RFC),
        .T_REF_GAP (T_REF_GAP),
        .CNT_W     (CNT_W)
    ) u_plan (
        .step      (q.step),
        .count_ok  (count_ok),
        .last_ref  (last_ref),
        .cmd       (pl_cmd),
        .gap_m1    (pl_gap_m1),
        .next_step (pl_next)
    );

    ddr2_mode_word #(
        .ROW_W (ROW_W),
        .BA_W  (BA_W)
    ) u_word (
        .step    (q.step),
        .cas_lat (cas_lat),
        .bl8_sel (bl8_sel),
        .wr_rec  (wr_rec),
        .odt_75  (odt_75),
        .ba      (wb_ba),
        .addr    (wb_addr)
    );

    always_comb begin
        d      = q;
        d.cmd  = q.cke ? CMD_NOP : CMD_DESEL;
        d.ba   = '0;
        d.addr = '0;
        if (start) begin
            d = SEQ_RST;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else if (q.step == STP_DONE) begin
            d.done = 1'b1;
        end else begin
            d.cke  = 1'b1;
            d.cmd  = pl_cmd;
            d.ba   = wb_ba;
            d.addr = wb_addr;
            d.cnt  = pl_gap_m1;
            d.step = pl_next;
            if (q.step == STP_PWR_NOP) d.err = !count_ok;
            if (q.step == STP_AREF)    d.ref_n = last_ref ? '0 : q.ref_n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign cke                        = q.cke;
    assign {cs_n, ras_n, cas_n, we_n} = q.cmd;
    assign ba                         = q.ba;
    assign addr                       = q.addr;
    assign init_done                  = q.done;
    assign error                      = q.err;

    // Interval tracker used by the assertions below
    logic             is_cmd;
    logic [CNT_W-1:0] since_q;
    logic             last_mode_q;

    assign is_cmd = (q.cmd == CMD_MRS) || (q.cmd == CMD_REF) || (q.cmd == CMD_PRE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q     <= '0;
            last_mode_q <= 1'b0;
        end else if (start) begin
            since_q     <= '0;
            last_mode_q <= 1'b0;
        end else if (is_cmd) begin
            since_q     <= CNT_W'(1);
            last_mode_q <= (q.cmd == CMD_MRS);
        end else if (since_q != '1) begin
            since_q     <= since_q + 1'b1;
        end
    end

    AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd == CMD_PRE) |-> (addr[10] && ba == '0)); // R3

    AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_mode_q) |-> (since_q >= CNT_W'(T_MRD))); // R8

    AST_NO_EMRS_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (error && q.cmd == CMD_MRS) |-> (ba != BA_W'(1))); // R9

    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cmd != CMD_DESEL) |-> cke); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && !start) |=> init_done); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (q.cmd == CMD_NOP)); // R10

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!init_done && !error && !cke)); // R11

endmodule

// File: tb/ddr2_pwrup_seq_bench.sv
module ddr2_pwrup_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 14;
    localparam int BA_W       = 3;
    localparam int T_STABLE   = 20;
    localparam int T_RP       = 3;
    localparam int T_MRD      = 2;
    localparam int T_RFC      = 5;
    localparam int T_REF_GAP  = 7;
    localparam int N_REF      = 8;

    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_NOP = 4'b0111;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       dimm_cnt = 2'd1;
    logic [2:0]       cas_lat = 3'd3;
    logic             bl8_sel = 1'b0;
    logic [2:0]       wr_rec = 3'd4;
    logic             cke, cs_n, ras_n, cas_n, we_n, init_done, error;
    logic [BA_W-1:0]  ba;
    logic [ROW_W-1:0] addr;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2_pwrup_seq #(
        .ROW_W (ROW_W), .BA_W (BA_W), .T_STABLE (T_STABLE), .T_RP (T_RP),
        .T_MRD (T_MRD), .T_RFC (T_RFC), .T_REF_GAP (T_REF_GAP), .N_REF (N_REF)
    ) u_ddr2_pwrup_seq (
        .clk (clk), .rst_n (rst_n), .start (start), .dimm_cnt (dimm_cnt),
        .cas_lat (cas_lat), .bl8_sel (bl8_sel), .wr_rec (wr_rec),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .init_done (init_done), .error (error)
    );

    // Cycle counter and command monitor
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [3:0] lg_cmd [0:255];
    int         lg_ba  [0:255];
    int         lg_addr[0:255];
    int         lg_cyc [0:255];
    int         log_n = 0;
    int         cke_rise_cyc = 0;
    int         done_rise_cyc = 0;
    logic       cke_prev = 1'b0;
    logic       done_prev = 1'b0;

    always @(negedge clk) begin
        logic [3:0] pins;
        pins = {cs_n, ras_n, cas_n, we_n};
        if (rst_n && (pins == C_MRS || pins == C_REF || pins == C_PRE) && log_n < 256) begin
            lg_cmd[log_n]  <= pins;
            lg_ba[log_n]   <= int'(ba);
            lg_addr[log_n] <= int'(addr);
            lg_cyc[log_n]  <= cyc;
            log_n          <= log_n + 1;
        end
        if (cke && !cke_prev) cke_rise_cyc <= cyc;
        if (init_done && !done_prev) done_rise_cyc <= cyc;
        cke_prev  <= cke;
        done_prev <= init_done;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected series
    logic [3:0] e_cmd[0:15];
    int         e_ba[0:15];
    int         e_addr[0:15];
    int         e_gap[0:15];
    string      e_tag[0:15];
    string      e_gtag[0:15];
    int         e_n;
    bit         e_err;

    task automatic add_exp(input logic [3:0] c, input int b, input int a, input int g,
                           input string tg, input string gt);
        e_cmd[e_n] = c; e_ba[e_n] = b; e_addr[e_n] = a; e_gap[e_n] = g;
        e_tag[e_n] = tg; e_gtag[e_n] = gt;
        e_n++;
    endtask

    task automatic build_exp();
        bit good;
        int term;
        int fin;
        good = (dimm_cnt == 2'd1) || (dimm_cnt == 2'd2);
        term = (dimm_cnt == 2'd2) ? 'h004 : 'h040;
        fin  = (int'(wr_rec) << 9) | (int'(cas_lat) << 4) | 'h8 | (bl8_sel ? 3 : 2);
        e_n  = 0;
        add_exp(C_PRE, 0, 'h400, T_STABLE, "R3", "R8");
        if (good) add_exp(C_MRS, 1, term, T_RP, "R4", "R8");
        add_exp(C_MRS, 0, 'h100, good ? T_MRD : T_RP, "R4", good ? "R8" : "R9");
        add_exp(C_PRE, 0, 'h400, T_MRD, "R3", "R8");
        for (int k = 0; k < N_REF; k++)
            add_exp(C_REF, 0, 0, (k == 0) ? T_RP : T_REF_GAP, "R5", (k == 0) ? "R8" : "R5");
        add_exp(C_MRS, 0, fin, T_RFC, "R6", "R5");
        if (good) begin
            add_exp(C_MRS, 1, 'h380 | term, T_MRD, "R7", "R8");
            add_exp(C_MRS, 1, term, T_MRD, "R7", "R8");
        end
        e_err = !good;
    endtask

    task automatic restart_seq(output int base);
        @(negedge clk); start = 1'b1;
        @(negedge clk); #1; start = 1'b0;
        base = log_n;
        chk(cke == 1'b0, "R11", "cke after start", int'(cke), 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R11", "pins after start",
            int'({cs_n, ras_n, cas_n, we_n}), 'hF);
        chk(init_done == 1'b0, "R11", "init_done after start", int'(init_done), 0);
        chk(error == 1'b0, "R11", "error after start", int'(error), 0);
    endtask

    task automatic check_run(input int base, input string name);
        bit seen;
        int n;
        int last_c;
        seen = 1'b0;
        build_exp();
        for (int w = 0; w < 2000 && !seen; w++) begin
            @(negedge clk); #1;
            seen = init_done;
        end
        chk(seen, "R10", {name, " init_done reached"}, int'(seen), 1);
        n = log_n - base;
        chk(n == e_n, e_err ? "R9" : "R2", {name, " command count"}, n, e_n);
        for (int i = 0; i < e_n && i < n; i++) begin
            chk(lg_cmd[base+i] == e_cmd[i], "R2", $sformatf("%s cmd #%0d code", name, i),
                int'(lg_cmd[base+i]), int'(e_cmd[i]));
            chk(lg_ba[base+i] == e_ba[i], e_tag[i], $sformatf("%s cmd #%0d ba", name, i),
                lg_ba[base+i], e_ba[i]);
            chk(lg_addr[base+i] == e_addr[i], e_tag[i], $sformatf("%s cmd #%0d addr", name, i),
                lg_addr[base+i], e_addr[i]);
            if (i == 0)
                chk(lg_cyc[base] - cke_rise_cyc == T_STABLE, "R8", {name, " cke to first precharge"},
                    lg_cyc[base] - cke_rise_cyc, T_STABLE);
            else
                chk(lg_cyc[base+i] - lg_cyc[base+i-1] == e_gap[i], e_gtag[i],
                    $sformatf("%s gap before cmd #%0d", name, i),
                    lg_cyc[base+i] - lg_cyc[base+i-1], e_gap[i]);
        end
        if (n > 0) begin
            last_c = lg_cyc[base+n-1];
            chk(done_rise_cyc - last_c == T_MRD, "R10", {name, " done after last command"},
                done_rise_cyc - last_c, T_MRD);
        end
        chk(error == e_err, "R9", {name, " error flag"}, int'(error), int'(e_err));
        n = log_n;
        repeat (8) @(negedge clk);
        #1;
        chk(log_n == n, "R10", {name, " no commands after done"}, log_n - n, 0);
        chk(init_done == 1'b1, "R10", {name, " init_done held"}, int'(init_done), 1);
        chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R2", {name, " NOP on idle bus"},
            int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
    endtask

    task automatic t_reset_and_first();
        int base;
        dimm_cnt = 2'd1; cas_lat = 3'd3; bl8_sel = 1'b0; wr_rec = 3'd4;
        repeat (3) @(negedge clk);
        #1;
        chk(cke == 1'b0, "R1", "cke in reset", int'(cke), 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1", "pins in reset",
            int'({cs_n, ras_n, cas_n, we_n}), 'hF);
        chk(init_done == 1'b0 && error == 1'b0, "R1", "flags in reset",
            int'({init_done, error}), 0);
        rst_n = 1'b1;
        base = log_n;
        @(negedge clk); #1;
        chk(cke == 1'b1, "R1", "cke after release", int'(cke), 1);
        chk({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1", "NOP after release",
            int'({cs_n, ras_n, cas_n, we_n}), int'(C_NOP));
        check_run(base, "one_dimm_bl4");
    endtask

    task automatic t_unsupported(input logic [1:0] cnt);
        int base;
        dimm_cnt = cnt; cas_lat = 3'd4; bl8_sel = 1'b1; wr_rec = 3'd1;
        restart_seq(base);
        @(negedge clk); #1;
        chk(error == 1'b1, "R9", "error rises with cke", int'(error), 1);
        check_run(base, $sformatf("bad_count_%0d", cnt));
    endtask

    task automatic t_two_dimms();
        int base;
        dimm_cnt = 2'd2; cas_lat = 3'd5; bl8_sel = 1'b1; wr_rec = 3'd2;
        restart_seq(base);
        check_run(base, "two_dimm_bl8");
    endtask

    task automatic t_restart_mid();
        int base;
        dimm_cnt = 2'd1; cas_lat = 3'd6; bl8_sel = 1'b0; wr_rec = 3'd7;
        restart_seq(base);
        repeat (45) @(negedge clk);
        #1;
        chk(init_done == 1'b0, "R11", "mid-series not done", int'(init_done), 0);
        dimm_cnt = 2'd2; cas_lat = 3'd2; bl8_sel = 1'b1; wr_rec = 3'd5;
        restart_seq(base);
        check_run(base, "restart_mid");
    endtask

    initial begin
        t_reset_and_first();
        t_unsupported(2'd0);
        t_two_dimms();
        t_unsupported(2'd3);
        t_restart_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule